// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block translates virtual addresses to physical addresses with a fully associative table of 48 slots. Each slot covers two adjacent 4 KiB virtual pages, one even and one odd, so the table can map up to 96 pages at once. A lookup compares the virtual page-pair tag and the address-space identifier against every slot in parallel. The hit, miss, multi-hit and physical-address outputs are combinational and valid in the same cycle as the request, so the lookup can run alongside cache indexing.

Addresses whose top three bits are `100` form an untranslated kernel window. They skip the table: the physical address is the virtual address with those three bits cleared, and the lookup always hits. Every other address goes through the table. On a miss the miss handler walks its tables and installs the translation through the refill port, then the access is retried. The refill port writes either a named slot or a slot picked by a free-running down-counter. A reserved-count register protects the low-numbered slots from the second kind of write.

Top module: `pair_tlb`

## Requirements
- R1: A slot holds a 19-bit tag (virtual address bits 31:13), an address-space number, a global flag, and for each page half a 20-bit frame number and a valid bit. Address bit 12 = 0 selects the even half and 1 selects the odd half. On a hit the physical address is {frame, VA[11:0]}.
- R2: A slot matches only if its tag equals VA[31:13] and either its stored address-space number equals `lkAsid` or its global flag is set.
- R3: The lookup is a miss when no slot matches, or when the matching slot's valid bit for the selected half is clear. On a miss `lkMiss`=1, `lkHit`=0 and `lkPa`=0.
- R4: Results appear combinationally in the request cycle. With `lkReq`=0, `lkHit`, `lkMiss`, `lkMultiHit` and `lkPa` are all 0. With `lkReq`=1, exactly one of hit or miss is 1.
- R5: When VA[31:29]=3'b100 the lookup hits whatever the table holds, `lkMultiHit`=0, and `lkPa` is VA with bits 31:29 cleared.
- R6: A write is stored at the next rising clock edge and is not visible before it. An indexed write (`wrRandom`=0) updates exactly slot `wrIdx`, including reserved slots.
- R7: A random write (`wrRandom`=1) never targets a slot below the reserved count. Random writes on consecutive cycles go to distinct slots until all slots from the reserved count up to 47 have been used.
- R8: When the reserved count is 48 or more, random writes change no slot.
- R9: When several slots match, the lowest-numbered one supplies the result and `lkMultiHit` is 1.
- R10: Reset clears every valid bit and sets the reserved count to zero, so random writes can then reach slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkReq | input | 1 | Lookup request |
| lkVa | input | 32 | Lookup virtual address |
| lkAsid | input | 8 | Current address-space number |
| lkHit | output | 1 | Translation found |
| lkMiss | output | 1 | Translation absent or invalid |
| lkMultiHit | output | 1 | More than one slot matched |
| lkPa | output | 32 | Physical address, zero on miss |
| wrEn | input | 1 | Refill write strobe |
| wrRandom | input | 1 | 1: counter-chosen slot, 0: slot `wrIdx` |
| wrIdx | input | 6 | Explicit slot number |
| wrTag | input | 19 | Page-pair tag to store |
| wrAsid | input | 8 | Address-space number to store |
| wrGlobal | input | 1 | Global flag to store |
| wrPfnEven | input | 20 | Even-page frame number |
| wrValidEven | input | 1 | Even-page valid |
| wrPfnOdd | input | 20 | Odd-page frame number |
| wrValidOdd | input | 1 | Odd-page valid |
| rsvWe | input | 1 | Load the reserved-count register |
| rsvVal | input | 6 | New reserved count |

## Verification
The commit assertion assumes `wrIdx` is below 48 for indexed writes. The bench only uses slot numbers 0 to 47, and writes out-of-range indices nowhere. The checks on the random write target assume the reserved count changes only through `rsvWe`, and the bench changes it only between write bursts. Lookup tags are kept clear of the untranslated window so that table behaviour and bypass behaviour are exercised separately. Duplicate tags are installed deliberately in one scenario only.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int unsigned VA_W       = 32;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned PFN_W      = 20;
  localparam int unsigned ASID_W     = 8;
  localparam int unsigned N_ENTRIES  = 48;
  localparam int unsigned SEG_W      = 3;
  localparam logic [SEG_W-1:0] BYPASS_SEG = 3'b100;

  localparam int unsigned IDX_W = $clog2(N_ENTRIES);
  localparam int unsigned CNT_W = $clog2(N_ENTRIES + 1);
  localparam int unsigned TAG_W = VA_W - PAGE_SHIFT - 1;
  localparam int unsigned PA_W  = PFN_W + PAGE_SHIFT;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PFN_W-1:0]  pfnEven;
    logic              vEven;
    logic [PFN_W-1:0]  pfnOdd;
    logic              vOdd;
  } entry_t;

  typedef struct packed {
    logic             we;
    logic [IDX_W-1:0] idx;
  } wrStrobe_t;
endpackage

// File: rtl/ptlb_ctrl.sv
module ptlb_ctrl
  import ptlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrRandom,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             rsvWe,
  input  logic [CNT_W-1:0] rsvVal,
  output wrStrobe_t        strb
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_ENTRIES - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(N_ENTRIES);

  logic [CNT_W-1:0] rsvCnt;
  logic [IDX_W-1:0] randIdx;
  logic [IDX_W-1:0] randNext;
  logic [IDX_W-1:0] randPick;
  logic             randOk;

  always_comb begin
    if ((CNT_W'(randIdx) <= rsvCnt) || (randIdx == '0))
      randNext = TOP_IDX;
    else
      randNext = randIdx - 1'b1;
  end

  assign randPick = (CNT_W'(randIdx) < rsvCnt) ? TOP_IDX : randIdx;
  assign randOk   = rsvCnt < FULL_CNT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsvCnt  <= '0;
      randIdx <= TOP_IDX;
    end else begin
      randIdx <= randNext;
      if (rsvWe) rsvCnt <= rsvVal;
    end
  end

  always_comb begin
    strb.we  = wrEn && (!wrRandom || randOk);
    strb.idx = wrRandom ? randPick : wrIdx;
  end

  // R7
  rand_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.we && wrRandom) |-> (CNT_W'(strb.idx) >= rsvCnt));

  // R8
  rand_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrRandom && (rsvCnt >= FULL_CNT)) |-> !strb.we);

  // R7
  rand_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.we && wrRandom) |-> (strb.idx <= TOP_IDX));
endmodule

// File: rtl/ptlb_datapath.sv
module ptlb_datapath
  import ptlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  entry_t            wrEntry,
  input  logic              lkReq,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [ASID_W-1:0] lkAsid,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkMultiHit,
  output logic [PA_W-1:0]   lkPa
);
  entry_t               ent [N_ENTRIES];
  logic [N_ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]     selIdx;
  logic [TAG_W-1:0]     vaTag;
  logic                 oddSel;
  logic                 isBypass;
  logic                 halfValid;
  logic [PFN_W-1:0]     halfPfn;
  logic                 mappedHit;
  logic [PA_W-1:0]      bypassPa;
  entry_t               selEnt;

  assign vaTag    = lkVa[VA_W-1 -: TAG_W];
  assign oddSel   = lkVa[PAGE_SHIFT];
  assign isBypass = lkVa[VA_W-1 -: SEG_W] == BYPASS_SEG;
  assign bypassPa = PA_W'(lkVa[VA_W-SEG_W-1:0]);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)
        ent[i] <= '0;
      else if (strb.we && (strb.idx == IDX_W'(i)))
        ent[i] <= wrEntry;
    end
    assign matchVec[i] = (ent[i].tag == vaTag) &&
                         (ent[i].glob || (ent[i].asid == lkAsid));
  end

  always_comb begin
    selIdx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (matchVec[i]) selIdx = IDX_W'(i);
  end

  assign selEnt    = ent[selIdx];
  assign halfValid = oddSel ? selEnt.vOdd : selEnt.vEven;
  assign halfPfn   = oddSel ? selEnt.pfnOdd : selEnt.pfnEven;
  assign mappedHit = (|matchVec) && halfValid;

  always_comb begin
    lkHit      = lkReq && (isBypass || mappedHit);
    lkMiss     = lkReq && !isBypass && !mappedHit;
    lkMultiHit = lkReq && !isBypass && ($countones(matchVec) > 1);
    if (!lkReq)         lkPa = '0;
    else if (isBypass)  lkPa = bypassPa;
    else if (mappedHit) lkPa = {halfPfn, lkVa[PAGE_SHIFT-1:0]};
    else                lkPa = '0;
  end

  // R6
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.we && (strb.idx < IDX_W'(N_ENTRIES))) |=>
      (ent[$past(strb.idx)] == $past(wrEntry)));

  // R3
  miss_pa_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkMiss |-> ((lkPa == '0) && !lkHit));

  // R4
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkReq |-> $onehot({lkHit, lkMiss}));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkReq |-> (!lkHit && !lkMiss && !lkMultiHit && (lkPa == '0)));

  // R5
  bypass_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkReq && isBypass) |-> (lkHit && !lkMultiHit && (lkPa[PA_W-1 -: SEG_W] == '0)));
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import ptlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkReq,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [ASID_W-1:0] lkAsid,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkMultiHit,
  output logic [PA_W-1:0]   lkPa,
  input  logic              wrEn,
  input  logic              wrRandom,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [PFN_W-1:0]  wrPfnEven,
  input  logic              wrValidEven,
  input  logic [PFN_W-1:0]  wrPfnOdd,
  input  logic              wrValidOdd,
  input  logic              rsvWe,
  input  logic [CNT_W-1:0]  rsvVal
);
  wrStrobe_t strb;
  entry_t    wrEntry;

  assign wrEntry = '{tag: wrTag, asid: wrAsid, glob: wrGlobal,
                     pfnEven: wrPfnEven, vEven: wrValidEven,
                     pfnOdd: wrPfnOdd, vOdd: wrValidOdd};

  ptlb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRandom(wrRandom),
    .wrIdx(wrIdx), .rsvWe(rsvWe), .rsvVal(rsvVal), .strb(strb)
  );

  ptlb_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrEntry(wrEntry),
    .lkReq(lkReq), .lkVa(lkVa), .lkAsid(lkAsid),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkMultiHit(lkMultiHit), .lkPa(lkPa)
  );
endmodule

// File: tb/pair_tlb_tb_top.sv
`timescale 1ns/1ps
module pair_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkReq = 1'b0;
  logic [31:0] lkVa = '0;
  logic [7:0]  lkAsid = '0;
  logic        lkHit, lkMiss, lkMultiHit;
  logic [31:0] lkPa;
  logic        wrEn = 1'b0, wrRandom = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [18:0] wrTag = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0;
  logic [19:0] wrPfnEven = '0, wrPfnOdd = '0;
  logic        wrValidEven = 1'b0, wrValidOdd = 1'b0;
  logic        rsvWe = 1'b0;
  logic [5:0]  rsvVal = '0;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pair_tlb dut_i (
    .clk(clk), .rstN(rstN), .lkReq(lkReq), .lkVa(lkVa), .lkAsid(lkAsid),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkMultiHit(lkMultiHit), .lkPa(lkPa),
    .wrEn(wrEn), .wrRandom(wrRandom), .wrIdx(wrIdx), .wrTag(wrTag),
    .wrAsid(wrAsid), .wrGlobal(wrGlobal), .wrPfnEven(wrPfnEven),
    .wrValidEven(wrValidEven), .wrPfnOdd(wrPfnOdd), .wrValidOdd(wrValidOdd),
    .rsvWe(rsvWe), .rsvVal(rsvVal)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkVa(input logic [18:0] tag, input bit odd,
                                       input logic [11:0] off);
    return {tag, odd, off};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0; rsvWe = 1'b0; lkReq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid);
    @(negedge clk);
    lkReq = 1'b1; lkVa = va; lkAsid = asid;
    #2;
  endtask

  task automatic setWr(input bit rnd, input logic [5:0] idx, input logic [18:0] tag,
                       input logic [7:0] asid, input bit glob,
                       input logic [19:0] pe, input bit ve,
                       input logic [19:0] po, input bit vo);
    wrEn = 1'b1; wrRandom = rnd; wrIdx = idx; wrTag = tag; wrAsid = asid;
    wrGlobal = glob; wrPfnEven = pe; wrValidEven = ve; wrPfnOdd = po; wrValidOdd = vo;
  endtask

  task automatic writeIdx(input logic [5:0] idx, input logic [18:0] tag,
                          input logic [7:0] asid, input bit glob,
                          input logic [19:0] pe, input bit ve,
                          input logic [19:0] po, input bit vo);
    @(negedge clk);
    setWr(1'b0, idx, tag, asid, glob, pe, ve, po, vo);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setRsv(input logic [5:0] n);
    @(negedge clk);
    rsvWe = 1'b1; rsvVal = n;
    @(negedge clk);
    rsvWe = 1'b0;
  endtask

  task automatic randBurst(input logic [18:0] base, input int count);
    for (int k = 0; k < count; k++) begin
      @(negedge clk);
      setWr(1'b1, 6'd0, base + 19'(k), 8'd1, 1'b1, 20'(k), 1'b1, 20'h0, 1'b0);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic countHits(input logic [18:0] base, input int count, output int hits);
    hits = 0;
    for (int k = 0; k < count; k++) begin
      look(mkVa(base + 19'(k), 1'b0, 12'h0), 8'd1);
      if (lkHit) hits++;
    end
  endtask

  // R10: reset leaves every slot invalid
  task automatic testReset();
    look(mkVa(19'h0, 1'b0, 12'h0), 8'd0);
    check(lkMiss && !lkHit && lkPa == 0, "R10 reset miss tag0", {lkHit, lkMiss}, 2'b01);
    look(mkVa(19'h123, 1'b1, 12'h0), 8'd0);
    check(lkMiss && lkPa == 0, "R10 reset miss tag123", lkPa, 0);
  endtask

  // R1, R6: paired halves and next-edge visibility
  task automatic testPair();
    @(negedge clk);
    setWr(1'b0, 6'd5, 19'h10, 8'd3, 1'b0, 20'hAAAAA, 1'b1, 20'h55555, 1'b1);
    lkReq = 1'b1; lkVa = mkVa(19'h10, 1'b0, 12'h321); lkAsid = 8'd3;
    #2;
    check(lkMiss, "R6 write not visible before edge", lkMiss, 1);
    @(negedge clk);
    wrEn = 1'b0;
    #2;
    check(lkHit && lkPa == 32'hAAAAA321, "R1 even half", lkPa, 32'hAAAAA321);
    look(mkVa(19'h10, 1'b1, 12'hABC), 8'd3);
    check(lkHit && lkPa == 32'h55555ABC, "R1 odd half", lkPa, 32'h55555ABC);
  endtask

  // R2: address-space and global matching
  task automatic testAsid();
    look(mkVa(19'h10, 1'b0, 12'h0), 8'd4);
    check(lkMiss, "R2 foreign asid misses", lkMiss, 1);
    writeIdx(6'd6, 19'h20, 8'd9, 1'b1, 20'h01234, 1'b1, 20'h0, 1'b0);
    look(mkVa(19'h20, 1'b0, 12'h008), 8'd77);
    check(lkHit && lkPa == 32'h01234008, "R2 global hits any asid", lkPa, 32'h01234008);
  endtask

  // R3: invalid half and absent tag
  task automatic testValid();
    writeIdx(6'd7, 19'h30, 8'd3, 1'b0, 20'h0BEEF, 1'b1, 20'h0CAFE, 1'b0);
    look(mkVa(19'h30, 1'b1, 12'h111), 8'd3);
    check(lkMiss && !lkHit && lkPa == 0, "R3 invalid odd half misses", lkPa, 0);
    look(mkVa(19'h30, 1'b0, 12'h111), 8'd3);
    check(lkHit && lkPa == 32'h0BEEF111, "R3 valid even half hits", lkPa, 32'h0BEEF111);
    look(mkVa(19'h7777, 1'b0, 12'h0), 8'd3);
    check(lkMiss && lkPa == 0, "R3 absent tag misses", lkPa, 0);
  endtask

  // R4: idle request gives quiet outputs
  task automatic testIdle();
    @(negedge clk);
    lkReq = 1'b0; lkVa = mkVa(19'h10, 1'b0, 12'h0); lkAsid = 8'd3;
    #2;
    check(!lkHit && !lkMiss && !lkMultiHit && lkPa == 0, "R4 idle outputs zero",
          {lkHit, lkMiss, lkMultiHit}, 0);
  endtask

  // R5: untranslated kernel window
  task automatic testBypass();
    look(32'h9234_5678, 8'd200);
    check(lkHit && !lkMiss && lkPa == 32'h1234_5678, "R5 bypass address", lkPa, 32'h12345678);
    look(32'h8000_0FFF, 8'd0);
    check(lkHit && !lkMultiHit && lkPa == 32'h0000_0FFF, "R5 bypass low", lkPa, 32'h00000FFF);
  endtask

  // R9: duplicate tags, lowest slot wins
  task automatic testMulti();
    writeIdx(6'd20, 19'h40, 8'd3, 1'b0, 20'h22222, 1'b1, 20'h0, 1'b0);
    writeIdx(6'd10, 19'h40, 8'd3, 1'b0, 20'h11111, 1'b1, 20'h0, 1'b0);
    look(mkVa(19'h40, 1'b0, 12'h044), 8'd3);
    check(lkHit && lkPa == 32'h11111044, "R9 lowest slot supplies frame", lkPa, 32'h11111044);
    check(lkMultiHit, "R9 multi-hit flag", lkMultiHit, 1);
    look(mkVa(19'h10, 1'b0, 12'h0), 8'd3);
    check(!lkMultiHit, "R9 single match no flag", lkMultiHit, 0);
  endtask

  // R10, R7: after reset random writes reach every slot including 0
  task automatic testRandAfterReset();
    int hits;
    doReset();
    randBurst(19'h100, 48);
    countHits(19'h100, 48, hits);
    check(hits == 48, "R10 reserved count zero, all 48 slots filled", hits, 48);
  endtask

  // R7, R6, R8: reserved slots survive random writes
  task automatic testReserved();
    int hits;
    doReset();
    for (int i = 0; i < 48; i++)
      writeIdx(6'(i), 19'h200 + 19'(i), 8'd1, 1'b0, 20'h100 + 20'(i), 1'b1, 20'h0, 1'b0);
    setRsv(6'd10);
    randBurst(19'h300, 48);
    hits = 0;
    for (int i = 0; i < 10; i++) begin
      look(mkVa(19'h200 + 19'(i), 1'b0, 12'h0), 8'd1);
      if (lkHit && lkPa == {20'h100 + 20'(i), 12'h0}) hits++;
    end
    check(hits == 10, "R7 reserved slots intact", hits, 10);
    countHits(19'h200 + 19'd10, 38, hits);
    check(hits == 0, "R7 unreserved slots all replaced", hits, 0);
    countHits(19'h300, 48, hits);
    check(hits == 38, "R7 random writes spread over 38 slots", hits, 38);
    writeIdx(6'd3, 19'h500, 8'd1, 1'b0, 20'h00ABC, 1'b1, 20'h0, 1'b0);
    look(mkVa(19'h500, 1'b0, 12'h001), 8'd1);
    check(lkHit && lkPa == 32'h00ABC001, "R6 indexed write into reserved slot", lkPa, 32'h00ABC001);
    look(mkVa(19'h203, 1'b0, 12'h0), 8'd1);
    check(lkMiss, "R6 indexed write replaced slot 3 only", lkMiss, 1);
    setRsv(6'd48);
    randBurst(19'h600, 4);
    countHits(19'h600, 4, hits);
    check(hits == 0, "R8 random writes suppressed", hits, 0);
    countHits(19'h300 + 19'd10, 38, hits);
    check(hits == 38, "R8 table unchanged by suppressed writes", hits, 38);
  endtask

  initial begin
    doReset();
    testReset();
    testPair();
    testAsid();
    testValid();
    testIdle();
    testBypass();
    testMulti();
    testRandAfterReset();
    testReserved();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule